// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Lockout

This block turns an asynchronous serial line into bytes for a host. The line is
first brought into the clock domain through a short synchronizer. It is then
sampled on an oversampling enable pulse that runs at a fixed multiple of the
bit rate. A frame starts when the line falls and the low level is confirmed at
the middle of the start bit. The frame then carries the data bits, least
significant first, an optional parity bit and a stop bit. Each of these bits is
sampled at its centre.

A clean frame is copied into a receive data register, and a full flag is raised
that the host must clear. Three conditions are recorded in sticky flags that
stay set until the host clears them one by one:
- a frame that completes while the full flag is still up (overrun);
- a parity bit that does not match the configured parity;
- a stop bit that reads low.

While any of these flags is set, the receiver ignores the line completely. The
synchronized line level stays visible at all times, so a host that sees a
framing error can tell whether the line is held low (a break).

Top module: `serial_rx_guard`

## Requirements
- R1: After reset, rx_data is 0 and rx_full, ovr_err, par_err, frm_err, rx_irq and err_irq are all 0.
- R2: A frame is a low start bit, DATA_BITS data bits least significant first, a parity bit only when par_en is 1, and a stop bit. If rx_full is 0 when a frame ends, and parity and stop are good, the data goes to rx_data and rx_full becomes 1.
- R3: rx_irq equals rx_ie AND rx_full, delayed by one clock.
- R4: With par_en at 1, the expected parity bit is the XOR of the data bits XOR par_odd (0 selects even, 1 selects odd). A mismatch sets par_err, and rx_data and rx_full are left unchanged.
- R5: A stop bit sampled as 0 sets frm_err, and rx_data and rx_full are left unchanged.
- R6: line_level follows rxd after two clocks, including while the line is held low after a framing error.
- R7: If rx_full is still 1 when a frame ends, ovr_err is set and rx_data keeps the earlier byte.
- R8: While any of ovr_err, par_err or frm_err is 1, frames on the line change neither rx_data nor any flag.
- R9: Each error flag and rx_full stays set until a pulse on its own clear input. A clear pulse affects no other flag.
- R10: err_irq equals err_ie AND (ovr_err OR par_err OR frm_err), delayed by one clock.
- R11: A start is accepted only if the line is still low OVS/2 ticks after the falling edge. A shorter low pulse starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, OVS pulses per bit |
| rxd | input | 1 | Serial line, idle high |
| par_en | input | 1 | Frame carries a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rx_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| clr_full | input | 1 | Clear pulse for rx_full |
| clr_ovr | input | 1 | Clear pulse for ovr_err |
| clr_par | input | 1 | Clear pulse for par_err |
| clr_frm | input | 1 | Clear pulse for frm_err |
| rx_data | output | DATA_BITS | Receive data register |
| rx_full | output | 1 | Receive data register holds an unread byte |
| ovr_err | output | 1 | Sticky overrun flag |
| par_err | output | 1 | Sticky parity error flag |
| frm_err | output | 1 | Sticky framing error flag |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |
| line_level | output | 1 | Synchronized line level |

## Verification
Fixed bytes are sent first with no parity, even parity and odd parity. This
separates bit ordering and parity sense from plain data transfer. Random bytes,
random parity settings and occasional corrupted parity or stop bits are then
compared with a bench model of the flags and the held data.

Directed patterns cover the rest:
- A second frame sent without clearing rx_full separates overrun from normal loading.
- Frames sent while a flag is set show that the lockout holds.
- A line held low shows the break and the line-level readback.
- A short low glitch separates mid-bit start confirmation from plain edge detection.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    FS_IDLE,
    FS_START,
    FS_DATA,
    FS_PAR,
    FS_STOP
  } frame_st_t;

  typedef struct packed {
    logic par_bad;
    logic stop_bad;
  } frame_chk_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] r_q;

  always_ff @(posedge clk) begin
    if (rst) r_q <= '1;
    else     r_q <= {r_q[STAGES-2:0], d};
  end

  assign q = r_q[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 line,
  input  logic                 lock,
  input  logic                 par_en,
  input  logic                 par_odd,
  output logic                 evt,
  output logic [DATA_BITS-1:0] evt_data,
  output frame_chk_t           evt_chk
);
  localparam int CW = $clog2(OVS);
  localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] LAST     = CW'(OVS - 1);
  localparam logic [CW-1:0] MID      = CW'(OVS / 2 - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

  frame_st_t             st_q;
  logic [CW-1:0]         cnt_q;
  logic [BW-1:0]         idx_q;
  logic [DATA_BITS-1:0]  sh_q;
  logic                  pbit_q;
  logic                  prev_q;
  logic                  evt_q;
  logic [DATA_BITS-1:0]  data_q;
  frame_chk_t            chk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= FS_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pbit_q <= 1'b0;
      prev_q <= 1'b1;
      evt_q  <= 1'b0;
      data_q <= '0;
      chk_q  <= '0;
    end else begin
      evt_q <= 1'b0;
      if (tick) begin
        prev_q <= line;
        unique case (st_q)
          FS_IDLE: begin
            if (!lock && !evt_q && prev_q && !line) begin
              st_q  <= FS_START;
              cnt_q <= '0;
            end
          end
          FS_START: begin
            if (cnt_q == MID) begin
              cnt_q <= '0;
              idx_q <= '0;
              st_q  <= line ? FS_IDLE : FS_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          FS_DATA: begin
            if (cnt_q == LAST) begin
              cnt_q <= '0;
              sh_q  <= DATA_BITS'({line, sh_q} >> 1);
              idx_q <= idx_q + 1'b1;
              if (idx_q == LAST_BIT) st_q <= par_en ? FS_PAR : FS_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          FS_PAR: begin
            if (cnt_q == LAST) begin
              cnt_q  <= '0;
              pbit_q <= line;
              st_q   <= FS_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          FS_STOP: begin
            if (cnt_q == LAST) begin
              cnt_q          <= '0;
              evt_q          <= 1'b1;
              data_q         <= sh_q;
              chk_q.stop_bad <= ~line;
              chk_q.par_bad  <= par_en && (pbit_q != ((^sh_q) ^ par_odd));
              st_q           <= FS_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: st_q <= FS_IDLE;
        endcase
      end
    end
  end

  assign evt      = evt_q;
  assign evt_data = data_q;
  assign evt_chk  = chk_q;

  AST_LOCKED_IDLE: assert property (@(posedge clk) disable iff (rst)
    lock |-> st_q == FS_IDLE) else $error("receiver active while flags set"); // R8
endmodule

// File: rtl/srx_status.sv
module srx_status
  import srx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 evt,
  input  logic [DATA_BITS-1:0] evt_data,
  input  frame_chk_t           evt_chk,
  input  logic                 clr_full,
  input  logic                 clr_ovr,
  input  logic                 clr_par,
  input  logic                 clr_frm,
  input  logic                 rx_ie,
  input  logic                 err_ie,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_full,
  output logic                 ovr_err,
  output logic                 par_err,
  output logic                 frm_err,
  output logic                 rx_irq,
  output logic                 err_irq,
  output logic                 lock
);
  logic [DATA_BITS-1:0] data_q;
  logic full_q, ovr_q, par_q, frm_q, rxi_q, eri_q;
  logic set_ovr, set_par, set_frm, take;

  always_comb begin
    set_ovr = evt && full_q;
    set_par = evt && !full_q && evt_chk.par_bad;
    set_frm = evt && !full_q && evt_chk.stop_bad;
    take    = evt && !full_q && !evt_chk.par_bad && !evt_chk.stop_bad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      par_q  <= 1'b0;
      frm_q  <= 1'b0;
      rxi_q  <= 1'b0;
      eri_q  <= 1'b0;
    end else begin
      if (take) data_q <= evt_data;
      full_q <= take    | (full_q & ~clr_full);
      ovr_q  <= set_ovr | (ovr_q  & ~clr_ovr);
      par_q  <= set_par | (par_q  & ~clr_par);
      frm_q  <= set_frm | (frm_q  & ~clr_frm);
      rxi_q  <= rx_ie  & full_q;
      eri_q  <= err_ie & (ovr_q | par_q | frm_q);
    end
  end

  assign rx_data = data_q;
  assign rx_full = full_q;
  assign ovr_err = ovr_q;
  assign par_err = par_q;
  assign frm_err = frm_q;
  assign rx_irq  = rxi_q;
  assign err_irq = eri_q;
  assign lock    = ovr_q | par_q | frm_q;

  AST_RDR_HELD: assert property (@(posedge clk) disable iff (rst)
    $past(full_q) |-> $stable(data_q)) else $error("data overwritten while full"); // R7
  AST_STICKY_FRM: assert property (@(posedge clk) disable iff (rst)
    ($past(frm_q) && !$past(clr_frm)) |-> frm_q) else $error("frm flag lost"); // R9
  AST_STICKY_OVR: assert property (@(posedge clk) disable iff (rst)
    ($past(ovr_q) && !$past(clr_ovr)) |-> ovr_q) else $error("ovr flag lost"); // R9
  AST_LOAD_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $rose(full_q) |-> !$past(ovr_q | par_q | frm_q)) else $error("load under lockout"); // R8
endmodule

// File: rtl/serial_rx_guard.sv
module serial_rx_guard
  import srx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 os_tick,
  input  logic                 rxd,
  input  logic                 par_en,
  input  logic                 par_odd,
  input  logic                 rx_ie,
  input  logic                 err_ie,
  input  logic                 clr_full,
  input  logic                 clr_ovr,
  input  logic                 clr_par,
  input  logic                 clr_frm,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_full,
  output logic                 ovr_err,
  output logic                 par_err,
  output logic                 frm_err,
  output logic                 rx_irq,
  output logic                 err_irq,
  output logic                 line_level
);
  logic                 line_s;
  logic                 lock;
  logic                 evt;
  logic [DATA_BITS-1:0] evt_data;
  frame_chk_t           evt_chk;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rxd),
    .q   (line_s)
  );

  srx_framer #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_framer (
    .clk      (clk),
    .rst      (rst),
    .tick     (os_tick),
    .line     (line_s),
    .lock     (lock),
    .par_en   (par_en),
    .par_odd  (par_odd),
    .evt      (evt),
    .evt_data (evt_data),
    .evt_chk  (evt_chk)
  );

  srx_status #(.DATA_BITS(DATA_BITS)) u_status (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .evt_data (evt_data),
    .evt_chk  (evt_chk),
    .clr_full (clr_full),
    .clr_ovr  (clr_ovr),
    .clr_par  (clr_par),
    .clr_frm  (clr_frm),
    .rx_ie    (rx_ie),
    .err_ie   (err_ie),
    .rx_data  (rx_data),
    .rx_full  (rx_full),
    .ovr_err  (ovr_err),
    .par_err  (par_err),
    .frm_err  (frm_err),
    .rx_irq   (rx_irq),
    .err_irq  (err_irq),
    .lock     (lock)
  );

  assign line_level = line_s;
endmodule

// File: tb/serial_rx_guard_test.sv
`timescale 1ns/1ps
module serial_rx_guard_test;
  localparam int BITCLK = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic os_tick = 1'b0;
  logic rxd = 1'b1;
  logic par_en = 1'b0, par_odd = 1'b0, rx_ie = 1'b1, err_ie = 1'b1;
  logic clr_full = 1'b0, clr_ovr = 1'b0, clr_par = 1'b0, clr_frm = 1'b0;
  logic [7:0] rx_data;
  logic rx_full, ovr_err, par_err, frm_err, rx_irq, err_irq, line_level;

  int n_chk = 0;
  int n_bad = 0;

  serial_rx_guard uut (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
    .par_en(par_en), .par_odd(par_odd), .rx_ie(rx_ie), .err_ie(err_ie),
    .clr_full(clr_full), .clr_ovr(clr_ovr), .clr_par(clr_par), .clr_frm(clr_frm),
    .rx_data(rx_data), .rx_full(rx_full), .ovr_err(ovr_err), .par_err(par_err),
    .frm_err(frm_err), .rx_irq(rx_irq), .err_irq(err_irq), .line_level(line_level)
  );

  always #2.5 clk = ~clk;

  initial begin
    forever begin
      repeat (2) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  function automatic logic par_bit(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic pe, input logic po,
                            input logic bad_par, input logic bad_stop);
    par_en  = pe;
    par_odd = po;
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (pe) drive_bit(par_bit(d, po) ^ bad_par);
    drive_bit(~bad_stop);
    drive_bit(1'b1);
  endtask

  task automatic clear(input logic [3:0] m);
    {clr_frm, clr_par, clr_ovr, clr_full} = m;
    @(negedge clk);
    {clr_frm, clr_par, clr_ovr, clr_full} = 4'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] last;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 rx_data", 32'(rx_data), 0);
    check("R1 flags", {rx_full, ovr_err, par_err, frm_err}, 0);
    check("R1 irqs", {rx_irq, err_irq}, 0);
    check("R6 idle line_level", 32'(line_level), 1);

    // R2/R3 plain frame
    send_frame(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R2 data no parity", 32'(rx_data), 32'h A5);
    check("R2 full", 32'(rx_full), 1);
    check("R3 rx_irq enabled", 32'(rx_irq), 1);
    rx_ie = 1'b0;
    repeat (2) @(negedge clk);
    check("R3 rx_irq disabled", 32'(rx_irq), 0);
    rx_ie = 1'b1;
    clear(4'b0001);
    check("R9 full cleared", 32'(rx_full), 0);
    check("R3 rx_irq after clear", 32'(rx_irq), 0);

    // R4 good parity, even and odd
    send_frame(8'h3C, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R4 even parity data", 32'(rx_data), 32'h3C);
    check("R4 even parity no error", 32'(par_err), 0);
    clear(4'b0001);
    send_frame(8'h81, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R4 odd parity data", 32'(rx_data), 32'h81);
    check("R4 odd parity no error", 32'(par_err), 0);
    clear(4'b0001);

    // R4 bad parity, R10 error irq, R8 lockout
    send_frame(8'h0F, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R4 par_err set", 32'(par_err), 1);
    check("R4 data kept", 32'(rx_data), 32'h81);
    check("R4 full stays 0", 32'(rx_full), 0);
    check("R10 err_irq", 32'(err_irq), 1);
    err_ie = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 err_irq disabled", 32'(err_irq), 0);
    err_ie = 1'b1;
    send_frame(8'h11, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 locked data", 32'(rx_data), 32'h81);
    check("R8 locked full", 32'(rx_full), 0);
    check("R8 locked flags", {ovr_err, par_err, frm_err}, 3'b010);
    clear(4'b0100);
    check("R10 err_irq clears", 32'(err_irq), 0);
    send_frame(8'h11, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 resumes", 32'(rx_data), 32'h11);

    // R7 overrun
    send_frame(8'h33, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R7 ovr_err set", 32'(ovr_err), 1);
    check("R7 data kept", 32'(rx_data), 32'h11);
    check("R7 full kept", 32'(rx_full), 1);
    send_frame(8'h66, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 locked by overrun", 32'(rx_data), 32'h11);
    clear(4'b0011);
    send_frame(8'h44, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R7 recovered", 32'(rx_data), 32'h44);
    clear(4'b0001);

    // R5/R6 break
    par_en = 1'b0;
    rxd = 1'b0;
    repeat (12 * BITCLK) @(negedge clk);
    check("R5 frm_err on break", 32'(frm_err), 1);
    check("R5 data kept", 32'(rx_data), 32'h44);
    check("R5 full stays 0", 32'(rx_full), 0);
    check("R6 line_level low in break", 32'(line_level), 0);
    rxd = 1'b1;
    repeat (BITCLK) @(negedge clk);
    check("R6 line_level high", 32'(line_level), 1);
    clear(4'b0100);
    check("R9 other clear leaves frm_err", 32'(frm_err), 1);
    clear(4'b1000);
    check("R9 frm_err cleared", 32'(frm_err), 0);

    // R5 bad stop after good data
    send_frame(8'h7E, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R5 bad stop frm_err", 32'(frm_err), 1);
    check("R5 bad stop data kept", 32'(rx_data), 32'h44);
    clear(4'b1000);

    // R11 glitch rejection
    rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    check("R11 glitch no frame", {rx_full, frm_err, par_err}, 0);
    send_frame(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R11 frame after glitch", 32'(rx_data), 32'h5A);
    clear(4'b0001);

    // random frames
    last = 8'h5A;
    for (int k = 0; k < 40; k++) begin
      logic [7:0] d;
      logic pe, po, bp, bs;
      d  = 8'($urandom);
      pe = 1'($urandom);
      po = 1'($urandom);
      bp = pe && ($urandom % 6 == 0);
      bs = ($urandom % 8 == 0);
      send_frame(d, pe, po, bp, bs);
      if (bp || bs) begin
        check("R4 random par_err", 32'(par_err), 32'(bp));
        check("R5 random frm_err", 32'(frm_err), 32'(bs));
        check("R8 random data kept", 32'(rx_data), 32'(last));
        clear(4'b1100);
      end else begin
        check("R2 random data", 32'(rx_data), 32'(d));
        check("R2 random full", 32'(rx_full), 1);
        last = d;
        clear(4'b0001);
      end
    end

    summary();
    $finish;
  end
endmodule